// File: doc/BRIEF.md
# System-Control Interrupt and Exception Unit

This unit sits beside a small 32-bit processor core and owns the machine-control state that decides when normal instruction flow is abandoned. It keeps a status word (global enable, per-line mask, exception-level flag), a cause word (pending lines and last event code), the saved return address, the last faulting address, and a free-running tick counter with a match register that raises a timer request on interrupt line 5.

Each cycle the core presents the address of the instruction it is about to run, any synchronous exception request with its code and optional fault address, and an exception-return request. The unit answers in the same cycle with a redirect strobe and the target address: the fixed handler entry for exceptions and interrupts, or the saved return address for an exception return. Move-to and move-from accesses reach the registers by number: 8 fault address, 9 counter, 11 match value, 12 status, 13 cause, 14 return address.

Top module: `sysctl_unit`

## Requirements
- R1: After reset the status reads 0x00000010, and cause, return address, fault address, counter and match value all read 0; redirect is low.
- R2: Status read layout: bits 15:8 line mask, bit 4 always 1, bit 1 exception level, bit 0 global enable, all others 0; only those three fields are writable. A cause write changes only the event code in bits 6:2.
- R3: Cause bits 15:8 show the request lines one cycle after they are driven, whether or not a line is masked, and a masked line causes no redirect.
- R4: When (cause bits 15:8 AND status bits 15:8) is non-zero, global enable is 1 and exception level is 0, redirect is high in that cycle with target 0x80000180; at the next edge the return address takes the current PC, exception level becomes 1 and the event code becomes 0.
- R5: While exception level is 1 no interrupt is taken, even with an enabled request pending.
- R6: An exception request redirects to 0x80000180, sets exception level and stores its 5-bit code; the return address takes the current PC only if exception level was 0; the fault address register loads only when the address-valid input is high.
- R7: An exception-return request redirects to the stored return address in the same cycle and clears exception level at the next edge.
- R8: The counter adds 1 on every cycle with tick enable high; a counter write loads the written value and wins over a tick in the same cycle.
- R9: A tick that brings the counter to the match value latches a timer request; cause bit 13 shows it one cycle later, and a write to the match register clears it; with line 5 enabled the request causes an interrupt.
- R10: Priority is exception, then exception return, then interrupt; in a cycle with any redirect a register write is discarded.
- R11: The fault address register is read-only and any register number other than 8, 9, 11, 12, 13, 14 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counter advance enable |
| irq_lines | input | 8 | Interrupt request lines |
| exc_req | input | 1 | Synchronous exception request |
| exc_code | input | 5 | Event code of the exception |
| exc_addr_valid | input | 1 | Exception carries a fault address |
| exc_addr | input | 32 | Fault address |
| cur_pc | input | 32 | Address of the instruction about to execute |
| eret_req | input | 1 | Exception-return request |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 5 | Register number |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_sel |
| redirect | output | 1 | Core must redirect its PC this cycle |
| redirect_pc | output | 32 | Redirect target |

## Verification
The bench aims at the moments where the exception-level flag matters: a second exception while in a handler must leave the saved return address alone, so a design that overwrote it would lose the way back, and an enabled pending line under that flag must stay silent, or a design would re-enter the handler forever. It drives exception and return together, and a write together with a return, since a wrong priority would jump to the saved address instead of the handler or let software clobber the return address. The timer path is checked at the exact tick where the counter meets the match value and after the match write, where a design that missed the clear would keep interrupting, and the status word is written with all ones to catch writable reserved bits or a user-mode bit that reads 0.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int XLEN   = 32;
    localparam int NIRQ   = 8;
    localparam int CODE_W = 5;
    localparam int SEL_W  = 5;

    localparam logic [SEL_W-1:0] SEL_BADVA   = 5'd8;
    localparam logic [SEL_W-1:0] SEL_COUNT   = 5'd9;
    localparam logic [SEL_W-1:0] SEL_COMPARE = 5'd11;
    localparam logic [SEL_W-1:0] SEL_STATUS  = 5'd12;
    localparam logic [SEL_W-1:0] SEL_CAUSE   = 5'd13;
    localparam logic [SEL_W-1:0] SEL_EPC     = 5'd14;

    // field positions inside the status and cause words
    localparam int MASK_LSB  = 8;
    localparam int UM_BIT    = 4;
    localparam int EXL_BIT   = 1;
    localparam int IE_BIT    = 0;
    localparam int CODE_LSB  = 2;

    typedef struct packed {
        logic [NIRQ-1:0] im;
        logic            exl;
        logic            ie;
    } status_t;

    typedef struct packed {
        status_t           status;
        logic [NIRQ-1:0]   ip;
        logic [CODE_W-1:0] code;
        logic [XLEN-1:0]   epc;
        logic [XLEN-1:0]   badva;
    } ctl_state_t;

    typedef enum logic [1:0] {
        EV_NONE,
        EV_EXC,
        EV_ERET,
        EV_INT
    } event_e;

endpackage

// File: rtl/sysctl_timer.sv
module sysctl_timer #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    input  logic         wr_count,
    input  logic         wr_compare,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] count,
    output logic [W-1:0] compare,
    output logic         match_pend
);

    typedef struct packed {
        logic [W-1:0] count;
        logic [W-1:0] compare;
        logic         pend;
    } tmr_t;

    tmr_t         tmr_d, tmr_q;
    logic [W-1:0] count_inc;

    always_comb begin
        tmr_d     = tmr_q;
        count_inc = tmr_q.count + W'(1);
        if (tick_en) begin
            tmr_d.count = count_inc;
            if (count_inc == tmr_q.compare && !wr_count) begin
                tmr_d.pend = 1'b1;
            end
        end
        if (wr_count) begin
            tmr_d.count = wdata;
        end
        if (wr_compare) begin
            tmr_d.compare = wdata;
            tmr_d.pend    = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign count      = tmr_q.count;
    assign compare    = tmr_q.compare;
    assign match_pend = tmr_q.pend;

    // R8: a tick without a load advances the counter by one
    a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !wr_count) |=> (count == $past(count) + W'(1)));

    // R8: a load wins over a tick
    a_r8_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_count |=> (count == $past(wdata)));

    // R9: a match-value write always drops the timer request
    a_r9_compare_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wr_compare |=> !match_pend);

endmodule

// File: rtl/sysctl_irq_eval.sv
module sysctl_irq_eval #(
    parameter int N = 8
) (
    input  logic [N-1:0] ip,
    input  logic [N-1:0] im,
    input  logic         ie,
    input  logic         exl,
    output logic [N-1:0] masked,
    output logic         take
);

    for (genvar i = 0; i < N; i++) begin : g_line
        assign masked[i] = ip[i] & im[i];
    end

    assign take = (|masked) & ie & ~exl;

endmodule

// File: rtl/sysctl_unit.sv
module sysctl_unit
    import sysctl_pkg::*;
#(
    parameter logic [31:0] HANDLER_VEC = 32'h8000_0180,
    parameter int          TIMER_LINE  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [NIRQ-1:0]   irq_lines,
    input  logic              exc_req,
    input  logic [CODE_W-1:0] exc_code,
    input  logic              exc_addr_valid,
    input  logic [XLEN-1:0]   exc_addr,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic              eret_req,
    input  logic              reg_wr_en,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [XLEN-1:0]   reg_wdata,
    output logic [XLEN-1:0]   reg_rdata,
    output logic              redirect,
    output logic [XLEN-1:0]   redirect_pc
);

    ctl_state_t      st_d, st_q;
    event_e          ev;
    logic            wr_ok;
    logic            int_take;
    logic [NIRQ-1:0] masked_ip;
    logic [XLEN-1:0] tmr_count, tmr_compare;
    logic            tmr_pend;

    sysctl_irq_eval #(.N(NIRQ)) u_eval (
        .ip     (st_q.ip),
        .im     (st_q.status.im),
        .ie     (st_q.status.ie),
        .exl    (st_q.status.exl),
        .masked (masked_ip),
        .take   (int_take)
    );

    // event selection: exception, then return, then interrupt
    always_comb begin
        if (exc_req)       ev = EV_EXC;
        else if (eret_req) ev = EV_ERET;
        else if (int_take) ev = EV_INT;
        else               ev = EV_NONE;
    end

    assign wr_ok = reg_wr_en && (ev == EV_NONE);

    sysctl_timer #(.W(XLEN)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .wr_count   (wr_ok && reg_sel == SEL_COUNT),
        .wr_compare (wr_ok && reg_sel == SEL_COMPARE),
        .wdata      (reg_wdata),
        .count      (tmr_count),
        .compare    (tmr_compare),
        .match_pend (tmr_pend)
    );

    always_comb begin
        st_d = st_q;
        st_d.ip = irq_lines;
        st_d.ip[TIMER_LINE] = irq_lines[TIMER_LINE] | tmr_pend;
        unique case (ev)
            EV_EXC: begin
                st_d.status.exl = 1'b1;
                st_d.code       = exc_code;
                if (!st_q.status.exl) st_d.epc = cur_pc;
                if (exc_addr_valid)   st_d.badva = exc_addr;
            end
            EV_INT: begin
                st_d.status.exl = 1'b1;
                st_d.code       = '0;
                st_d.epc        = cur_pc;
            end
            EV_ERET: begin
                st_d.status.exl = 1'b0;
            end
            default: begin
                if (wr_ok) begin
                    case (reg_sel)
                        SEL_STATUS: begin
                            st_d.status.im  = reg_wdata[MASK_LSB +: NIRQ];
                            st_d.status.exl = reg_wdata[EXL_BIT];
                            st_d.status.ie  = reg_wdata[IE_BIT];
                        end
                        SEL_CAUSE: st_d.code = reg_wdata[CODE_LSB +: CODE_W];
                        SEL_EPC:   st_d.epc  = reg_wdata;
                        default:   ;
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // register read path
    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            SEL_BADVA:   reg_rdata = st_q.badva;
            SEL_COUNT:   reg_rdata = tmr_count;
            SEL_COMPARE: reg_rdata = tmr_compare;
            SEL_STATUS: begin
                reg_rdata[MASK_LSB +: NIRQ] = st_q.status.im;
                reg_rdata[UM_BIT]           = 1'b1;
                reg_rdata[EXL_BIT]          = st_q.status.exl;
                reg_rdata[IE_BIT]           = st_q.status.ie;
            end
            SEL_CAUSE: begin
                reg_rdata[MASK_LSB +: NIRQ]   = st_q.ip;
                reg_rdata[CODE_LSB +: CODE_W] = st_q.code;
            end
            SEL_EPC:     reg_rdata = st_q.epc;
            default:     reg_rdata = '0;
        endcase
    end

    assign redirect    = (ev != EV_NONE);
    assign redirect_pc = (ev == EV_ERET) ? st_q.epc : HANDLER_VEC;

    // R4: a taken interrupt saves the PC and raises the exception level
    a_r4_take_saves: assert property (@(posedge clk) disable iff (!rst_n)
        (int_take && !exc_req && !eret_req) |=>
            (st_q.status.exl && st_q.epc == $past(cur_pc) && st_q.code == '0));

    // R5: no interrupt while in a handler
    a_r5_no_nest: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.status.exl |-> !int_take);

    // R6: an exception under the exception level leaves the return address
    a_r6_epc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && st_q.status.exl) |=> $stable(st_q.epc));

    // R7: a return drops the exception level
    a_r7_eret_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (eret_req && !exc_req) |=> !st_q.status.exl);

    // R10: an exception always targets the handler entry
    a_r10_exc_first: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |-> (redirect && redirect_pc == HANDLER_VEC));

    // R2: the user-mode bit always reads as one
    a_r2_um_one: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == SEL_STATUS) |-> reg_rdata[UM_BIT]);

endmodule

// File: tb/sysctl_unit_test.sv
`timescale 1ns/1ps
module sysctl_unit_test;

    localparam logic [31:0] VEC_ADDR = 32'h8000_0180;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [7:0]  irq_lines = '0;
    logic        exc_req = 1'b0;
    logic [4:0]  exc_code = '0;
    logic        exc_addr_valid = 1'b0;
    logic [31:0] exc_addr = '0;
    logic [31:0] cur_pc = '0;
    logic        eret_req = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [4:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        redirect;
    logic [31:0] redirect_pc;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    sysctl_unit uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .irq_lines(irq_lines),
        .exc_req(exc_req), .exc_code(exc_code), .exc_addr_valid(exc_addr_valid),
        .exc_addr(exc_addr), .cur_pc(cur_pc), .eret_req(eret_req),
        .reg_wr_en(reg_wr_en), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .redirect(redirect), .redirect_pc(redirect_pc)
    );

    // {write, reg number, write data, expected read, requirement number}
    localparam int NV = 14;
    localparam logic [73:0] VECS [NV] = '{
        {1'b0, 5'd12, 32'h0, 32'h0000_0010, 4'd1},  // R1 status after reset
        {1'b0, 5'd13, 32'h0, 32'h0000_0000, 4'd1},  // R1 cause
        {1'b0, 5'd9,  32'h0, 32'h0000_0000, 4'd1},  // R1 counter
        {1'b0, 5'd11, 32'h0, 32'h0000_0000, 4'd1},  // R1 match value
        {1'b0, 5'd14, 32'h0, 32'h0000_0000, 4'd1},  // R1 return address
        {1'b1, 5'd12, 32'hFFFF_FFFF, 32'h0000_FF13, 4'd2}, // R2 only writable fields
        {1'b1, 5'd12, 32'h0, 32'h0000_0010, 4'd2},  // R2 clear, bit 4 stays
        {1'b1, 5'd13, 32'hFFFF_FFFF, 32'h0000_007C, 4'd2}, // R2 cause code only
        {1'b1, 5'd13, 32'h0, 32'h0000_0000, 4'd2},  // R2 cause clear
        {1'b1, 5'd14, 32'h1234_5678, 32'h1234_5678, 4'd2}, // R2 return address write
        {1'b1, 5'd9,  32'h0000_0055, 32'h0000_0055, 4'd8}, // R8 counter load
        {1'b1, 5'd8,  32'h0000_DEAD, 32'h0000_0000, 4'd11}, // R11 fault address read-only
        {1'b1, 5'd3,  32'hFFFF_FFFF, 32'h0000_0000, 4'd11}, // R11 unmapped
        {1'b0, 5'd31, 32'h0, 32'h0000_0000, 4'd11}  // R11 unmapped
    };

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] sel, logic [31:0] data);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_sel   = sel;
        reg_wdata = data;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_chk(logic [4:0] sel, logic [31:0] exp, string tag);
        reg_sel = sel;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic tick(int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 redirect after reset", {31'b0, redirect}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic        w;
            logic [4:0]  s;
            logic [31:0] dt, ex;
            logic [3:0]  rq;
            {w, s, dt, ex, rq} = VECS[i];
            if (w) wr(s, dt);
            rd_chk(s, ex, $sformatf("R%0d vector %0d", rq, i));
        end

        // R8: ticking and load-over-tick
        wr(9, 32'h0);
        tick(3);
        rd_chk(9, 32'h3, "R8 three ticks");
        @(negedge clk);
        tick_en = 1'b1; reg_wr_en = 1'b1; reg_sel = 5'd9; reg_wdata = 32'h100;
        @(negedge clk);
        tick_en = 1'b0; reg_wr_en = 1'b0;
        rd_chk(9, 32'h100, "R8 load wins over tick");

        // R3: masked pending line is visible but not taken
        cur_pc = 32'h0000_0128;
        irq_lines = 8'h04;
        @(negedge clk);
        rd_chk(13, 32'h0000_0400, "R3 pending shown");
        check("R3 masked no redirect", {31'b0, redirect}, 32'h0);

        // R4: enable line 2 and global enable
        wr(12, 32'h0000_0401);
        #1;
        check("R4 redirect", {31'b0, redirect}, 32'h1);
        check("R4 target", redirect_pc, VEC_ADDR);
        @(negedge clk);
        rd_chk(14, 32'h0000_0128, "R4 return address");
        rd_chk(12, 32'h0000_0413, "R4 exception level set");
        rd_chk(13, 32'h0000_0400, "R4 code zero");
        // R5: still pending, no re-entry
        check("R5 no nesting", {31'b0, redirect}, 32'h0);
        @(negedge clk);
        #1;
        check("R5 no nesting later", {31'b0, redirect}, 32'h0);

        // R7: drop the request, then return
        irq_lines = 8'h00;
        @(negedge clk);
        eret_req = 1'b1;
        #1;
        check("R7 redirect", {31'b0, redirect}, 32'h1);
        check("R7 target", redirect_pc, 32'h0000_0128);
        @(negedge clk);
        eret_req = 1'b0;
        rd_chk(12, 32'h0000_0411, "R7 exception level cleared");

        // R6: exception with fault address
        cur_pc = 32'h0000_0200;
        exc_req = 1'b1; exc_code = 5'd4; exc_addr_valid = 1'b1; exc_addr = 32'h0000_BAD0;
        #1;
        check("R6 target", redirect_pc, VEC_ADDR);
        @(negedge clk);
        exc_req = 1'b0; exc_addr_valid = 1'b0;
        rd_chk(14, 32'h0000_0200, "R6 return address");
        rd_chk(8, 32'h0000_BAD0, "R6 fault address");
        rd_chk(13, 32'h0000_0010, "R6 code");
        rd_chk(12, 32'h0000_0413, "R6 exception level");
        // R6: second exception inside the handler
        cur_pc = 32'h0000_0300;
        exc_req = 1'b1; exc_code = 5'd5; exc_addr = 32'h0000_1111;
        @(negedge clk);
        exc_req = 1'b0;
        rd_chk(14, 32'h0000_0200, "R6 return address frozen");
        rd_chk(8, 32'h0000_BAD0, "R6 fault address kept");
        rd_chk(13, 32'h0000_0014, "R6 second code");

        // R10: exception beats return
        exc_req = 1'b1; eret_req = 1'b1; exc_code = 5'd6;
        #1;
        check("R10 exception over return", redirect_pc, VEC_ADDR);
        @(negedge clk);
        exc_req = 1'b0;
        rd_chk(12, 32'h0000_0413, "R10 level still set");
        // R10: write during a return is dropped
        reg_wr_en = 1'b1; reg_sel = 5'd14; reg_wdata = 32'h0000_0999;
        #1;
        check("R10 return target", redirect_pc, 32'h0000_0200);
        @(negedge clk);
        eret_req = 1'b0; reg_wr_en = 1'b0;
        rd_chk(14, 32'h0000_0200, "R10 write discarded");
        rd_chk(12, 32'h0000_0411, "R10 return applied");

        // R9: timer match and clear, interrupts off
        wr(12, 32'h0);
        wr(13, 32'h0);
        wr(9, 32'h10);
        wr(11, 32'h12);
        tick(1);
        @(negedge clk);
        rd_chk(13, 32'h0, "R9 no early match");
        tick(1);
        @(negedge clk);
        rd_chk(13, 32'h0000_2000, "R9 match pending");
        rd_chk(9, 32'h12, "R8 counter at match");
        wr(11, 32'h50);
        @(negedge clk);
        rd_chk(13, 32'h0, "R9 match write clears");
        // R9: timer request taken when line 5 enabled
        wr(11, 32'h13);
        wr(12, 32'h0000_2001);
        tick(1);
        @(negedge clk);
        #1;
        check("R9 timer interrupt", {31'b0, redirect}, 32'h1);
        @(negedge clk);
        rd_chk(12, 32'h0000_2013, "R9 handler entered");

        summary();
        $finish;
    end

endmodule